// File: doc/BRIEF.md
# Cascadable Mux Fabric with Neighbour Expansion

This block is a combinational array of `N_CELLS` mux cells that share one routing pool built from the pin vector. The pins form four equal groups: A, B, C and D. Each cell has four candidate sources, called slots. A slot takes either a configured pin from its own group or the mux result of a nearby cell. A static 4x4 crossbar maps the slots onto the cell's four mux data inputs M0 to M3. A dynamic two-bit select then picks one of those four inputs.

The neighbour links reach the cells at distances -2, -1, +1 and +2, and they wrap around the ends of the array. A cell that combines four neighbours, each of which selects among four pins, therefore gives a 16:1 selection without a second pass through the pool. The cells split into two halves, normal and reflected. The two halves place a given neighbour into different slots. A configuration that requests a neighbour and also the direct group in the slot that neighbour occupies is flagged, and the neighbour is used. The fabric resolves neighbour chains in `LEVELS` unrolled passes. Configurations must therefore contain no loops and no chain longer than `LEVELS-1` hops.

Top module: `mxf_fabric`

## Requirements
- R1: Pin i belongs to group floor(i/Q), where Q = N_CELLS/4 and the groups are numbered 0 to 3 for A to D. When slot s has its group enable set and no neighbour takes it, the slot carries pin s*Q+idx, where idx is the slot's pin index field. An index of Q or more gives 0.
- R2: A slot with neither its group enable set nor any neighbour mapped onto it reads 0.
- R3: Neighbour enable bit k of a cell selects offset -2, -1, +1 or +2 for k = 0, 1, 2 or 3. Cells 0 to N_CELLS/2-1 are normal and put neighbour k into slot k. The other cells are reflected and put neighbour k into slot 3-k.
- R4: Neighbour indices wrap circularly, so cell 0 reaches cells N_CELLS-2 and N_CELLS-1, and the last cell reaches cells 0 and 1.
- R5: When a neighbour and the group enable of the same slot are both set, `conflict_o` of that cell reads 1 and the slot carries the neighbour. `conflict_o` depends only on the configuration.
- R6: Crossbar field k (2 bits) of a cell drives Mk from the slot it names. Several M inputs may take the same slot.
- R7: The select pair {s1,s0} of a cell, with bit 2c as s0, picks M0 for 00, M1 for 01, M2 for 11 and M3 for 10.
- R8: One pin may feed any number of cells at the same time.
- R9: A cell that uses four neighbours, each of which selects from pins, forms a 16:1 selection. Chains of up to LEVELS-1 hops give exact results.
- R10: The outputs follow the inputs with no clock. When all inputs are zero, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pins_i | input | N_CELLS | Pin values; group g occupies bits g*Q to g*Q+Q-1 |
| sel_i | input | 2*N_CELLS | Dynamic select pair per cell; bits 2c (s0) and 2c+1 (s1) |
| cfg_idx_i | input | N_CELLS*4*IW | Pin index per cell and slot at bit (c*4+s)*IW, IW = clog2(Q) |
| cfg_grp_en_i | input | 4*N_CELLS | Group enable per cell and slot at bit c*4+s |
| cfg_nbr_en_i | input | 4*N_CELLS | Neighbour enable per cell and offset code at bit c*4+k |
| cfg_xbar_i | input | 8*N_CELLS | Crossbar field per cell and mux input at bit (c*4+k)*2 |
| mux_o | output | N_CELLS | Per-cell mux result |
| conflict_o | output | N_CELLS | Per-cell configuration conflict flag |

## Verification
The block holds no state, so a wrong internal value shows on `mux_o` in the same evaluation as the stimulus that exposes it. The effect can surface several cells away, because neighbour results feed other cells. A wrong slot assignment for one hemisphere, or a wrong wrap index, only shows when the bench enables that particular neighbour and drives the pin behind it, so the directed cases target both halves and both ends of the array. Errors in the unrolled passes appear only on cells at the end of multi-hop chains. The random configurations therefore rank cells so that chains of every allowed depth occur.

// File: rtl/mxf_pkg.sv
package mxf_pkg;

    localparam int unsigned SLOTS = 4;

    // Neighbour offset codes: 0 -> -2, 1 -> -1, 2 -> +1, 3 -> +2
    typedef logic [1:0] nbr_code_t;

    // Dynamic select {s1,s0} in a reflected-binary order picks the mux input
    function automatic logic [1:0] dyn_to_m(input logic [1:0] s);
        logic [1:0] m;
        case (s)
            2'b00:   m = 2'd0;
            2'b01:   m = 2'd1;
            2'b11:   m = 2'd2;
            default: m = 2'd3;
        endcase
        return m;
    endfunction

    // Slot occupied by a neighbour, mirrored for the reflected half
    function automatic logic [1:0] nbr_slot(input nbr_code_t k, input logic reflected);
        return reflected ? (2'd3 - k) : k;
    endfunction

endpackage

// File: rtl/mxf_slot_src.sv
module mxf_slot_src
    import mxf_pkg::*;
#(
    parameter int unsigned GRP_PINS = 20,
    parameter int unsigned IDX_W    = 5,
    parameter bit          REFLECT  = 1'b0
) (
    input  logic [SLOTS-1:0][GRP_PINS-1:0] grp_pins_i,
    input  logic [SLOTS-1:0][IDX_W-1:0]    idx_i,
    input  logic [SLOTS-1:0]               grp_en_i,
    input  logic [SLOTS-1:0]               nbr_en_i,
    input  logic [SLOTS-1:0]               nbr_val_i,
    output logic [SLOTS-1:0]               slot_o,
    output logic                           conflict_o
);

    typedef struct packed {
        logic [SLOTS-1:0] slot;
        logic [SLOTS-1:0] taken;
        logic             conflict;
    } src_t;

    src_t src_d;

    always_comb begin
        src_d = '0;
        // Neighbour results claim their slot first
        for (int k = 0; k < SLOTS; k++) begin
            if (nbr_en_i[k]) begin
                src_d.taken[nbr_slot(2'(k), REFLECT)] = 1'b1;
                src_d.slot[nbr_slot(2'(k), REFLECT)]  = nbr_val_i[k];
            end
        end
        // Direct group pins fill the slots left free
        for (int s = 0; s < SLOTS; s++) begin
            if (grp_en_i[s]) begin
                if (src_d.taken[s]) begin
                    src_d.conflict = 1'b1;
                end else if (int'(idx_i[s]) < int'(GRP_PINS)) begin
                    src_d.slot[s] = grp_pins_i[s][idx_i[s]];
                end
            end
        end
    end

    assign slot_o     = src_d.slot;
    assign conflict_o = src_d.conflict;

endmodule

// File: rtl/mxf_xbar.sv
module mxf_xbar
    import mxf_pkg::*;
(
    input  logic [SLOTS-1:0]      slot_i,
    input  logic [SLOTS-1:0][1:0] route_i,
    output logic [SLOTS-1:0]      m_o
);

    logic [SLOTS-1:0] m_d;

    always_comb begin
        for (int k = 0; k < SLOTS; k++) begin
            m_d[k] = slot_i[route_i[k]];
        end
    end

    assign m_o = m_d;

    // R6: a uniform slot set leaves every mux input at that same value
    always_comb begin
        if (slot_i == '0 || slot_i == '1) begin
            a_r6_xbar_uniform: assert (m_o == slot_i)
                else $error("R6 crossbar output %b differs from uniform slots %b", m_o, slot_i);
        end
    end

endmodule

// File: rtl/mxf_cell_mux.sv
module mxf_cell_mux
    import mxf_pkg::*;
(
    input  logic [SLOTS-1:0] m_i,
    input  logic [1:0]       sel_i,
    output logic             y_o
);

    logic y_d;

    always_comb begin
        y_d = m_i[dyn_to_m(sel_i)];
    end

    assign y_o = y_d;

    // R7: the result is always one of the four data inputs
    always_comb begin
        a_r7_mux_member: assert (y_o ? (m_i != '0) : (m_i != '1))
            else $error("R7 result %b not among inputs %b", y_o, m_i);
    end

endmodule

// File: rtl/mxf_fabric.sv
module mxf_fabric
    import mxf_pkg::*;
#(
    parameter int unsigned N_CELLS = 80,
    parameter int unsigned LEVELS  = 3
) (
    input  logic [N_CELLS-1:0]                                   pins_i,
    input  logic [2*N_CELLS-1:0]                                 sel_i,
    input  logic [N_CELLS*SLOTS*$clog2(N_CELLS/SLOTS)-1:0]       cfg_idx_i,
    input  logic [SLOTS*N_CELLS-1:0]                             cfg_grp_en_i,
    input  logic [SLOTS*N_CELLS-1:0]                             cfg_nbr_en_i,
    input  logic [2*SLOTS*N_CELLS-1:0]                           cfg_xbar_i,
    output logic [N_CELLS-1:0]                                   mux_o,
    output logic [N_CELLS-1:0]                                   conflict_o
);

    localparam int unsigned GRP_PINS = N_CELLS / SLOTS;
    localparam int unsigned IDX_W    = $clog2(GRP_PINS);
    localparam int unsigned HALF     = N_CELLS / 2;
    localparam int unsigned CIDX_W   = SLOTS * IDX_W;

    logic [SLOTS-1:0][GRP_PINS-1:0] grp_pins;
    logic [N_CELLS-1:0]             lvl_out [LEVELS];
    logic [N_CELLS-1:0]             cf_lvl  [LEVELS];

    assign grp_pins = pins_i;

    for (genvar c = 0; c < N_CELLS; c++) begin : g_cell
        localparam int unsigned CM2 = (c + N_CELLS - 2) % N_CELLS;
        localparam int unsigned CM1 = (c + N_CELLS - 1) % N_CELLS;
        localparam int unsigned CP1 = (c + 1) % N_CELLS;
        localparam int unsigned CP2 = (c + 2) % N_CELLS;
        localparam bit          REFL = (c >= HALF);

        logic [SLOTS-1:0][IDX_W-1:0] idx;
        logic [SLOTS-1:0][1:0]       route;
        logic [SLOTS-1:0]            gen;
        logic [SLOTS-1:0]            nen;
        logic [1:0]                  sel;

        assign idx   = cfg_idx_i[c*CIDX_W +: CIDX_W];
        assign route = cfg_xbar_i[c*2*SLOTS +: 2*SLOTS];
        assign gen   = cfg_grp_en_i[c*SLOTS +: SLOTS];
        assign nen   = cfg_nbr_en_i[c*SLOTS +: SLOTS];
        assign sel   = sel_i[2*c +: 2];

        for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
            logic [SLOTS-1:0] nv;
            logic [SLOTS-1:0] slot;
            logic [SLOTS-1:0] m;
            logic             y;
            logic             cf;

            if (l == 0) begin : g_first
                assign nv = '0;
            end else begin : g_next
                assign nv = {lvl_out[l-1][CP2], lvl_out[l-1][CP1],
                             lvl_out[l-1][CM1], lvl_out[l-1][CM2]};
            end

            mxf_slot_src #(
                .GRP_PINS (GRP_PINS),
                .IDX_W    (IDX_W),
                .REFLECT  (REFL)
            ) src_i (
                .grp_pins_i (grp_pins),
                .idx_i      (idx),
                .grp_en_i   (gen),
                .nbr_en_i   (nen),
                .nbr_val_i  (nv),
                .slot_o     (slot),
                .conflict_o (cf)
            );

            mxf_xbar xbar_i (
                .slot_i  (slot),
                .route_i (route),
                .m_o     (m)
            );

            mxf_cell_mux mux_i (
                .m_i   (m),
                .sel_i (sel),
                .y_o   (y)
            );

            assign lvl_out[l][c] = y;
            assign cf_lvl[l][c]  = cf;
        end

        // R2: a cell with no source enabled at all reads 0
        always_comb begin
            if (nen == '0 && gen == '0) begin
                a_r2_empty_cell: assert (mux_o[c] == 1'b0)
                    else $error("R2 cell %0d drives %b with no source", c, mux_o[c]);
            end
        end

        // R9: a cell with no neighbour is already exact in the first pass
        always_comb begin
            if (nen == '0) begin
                a_r9_settled: assert (mux_o[c] == lvl_out[0][c])
                    else $error("R9 cell %0d final %b first pass %b", c, mux_o[c], lvl_out[0][c]);
            end
        end

        // R5: the conflict flag does not depend on neighbour data
        always_comb begin
            for (int l = 1; l < LEVELS; l++) begin
                a_r5_conflict_static: assert (cf_lvl[l][c] == cf_lvl[0][c])
                    else $error("R5 cell %0d conflict varies across passes", c);
            end
        end
    end

    assign mux_o      = lvl_out[LEVELS-1];
    assign conflict_o = cf_lvl[0];

endmodule

// File: tb/mxf_fabric_tb_top.sv
module mxf_fabric_tb_top;

    localparam int N  = 80;
    localparam int LV = 3;
    localparam int Q  = N / 4;
    localparam int IW = $clog2(Q);

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    int unsigned b_idx  [N][4];
    bit          b_gen  [N][4];
    bit          b_nen  [N][4];
    bit [1:0]    b_xs   [N][4];
    bit [1:0]    b_sel  [N];
    logic [N-1:0] b_pins;

    logic [N-1:0]          pins;
    logic [2*N-1:0]        sel;
    logic [N*4*IW-1:0]     cidx;
    logic [4*N-1:0]        cgen;
    logic [4*N-1:0]        cnen;
    logic [8*N-1:0]        cxb;
    logic [N-1:0]          mux_o;
    logic [N-1:0]          conflict_o;

    always_comb begin
        pins = b_pins;
        for (int c = 0; c < N; c++) begin
            sel[2*c +: 2] = b_sel[c];
            for (int s = 0; s < 4; s++) begin
                cidx[(c*4+s)*IW +: IW] = IW'(b_idx[c][s]);
                cgen[c*4+s]            = b_gen[c][s];
                cnen[c*4+s]            = b_nen[c][s];
                cxb[(c*4+s)*2 +: 2]    = b_xs[c][s];
            end
        end
    end

    mxf_fabric #(.N_CELLS(N), .LEVELS(LV)) dut_i (
        .pins_i       (pins),
        .sel_i        (sel),
        .cfg_idx_i    (cidx),
        .cfg_grp_en_i (cgen),
        .cfg_nbr_en_i (cnen),
        .cfg_xbar_i   (cxb),
        .mux_o        (mux_o),
        .conflict_o   (conflict_o)
    );

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog: run did not finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic clear_cfg();
        for (int c = 0; c < N; c++) begin
            b_sel[c] = 2'b00;
            for (int s = 0; s < 4; s++) begin
                b_idx[c][s] = 0; b_gen[c][s] = 0; b_nen[c][s] = 0; b_xs[c][s] = 2'd0;
            end
        end
        b_pins = '0;
    endtask

    // Select code that picks input m (R7)
    function automatic bit [1:0] code_of(input int m);
        case (m)
            0: return 2'b00;
            1: return 2'b01;
            2: return 2'b11;
            default: return 2'b10;
        endcase
    endfunction

    function automatic int wrap(input int v);
        return (v + N) % N;
    endfunction

    // Reference: iterate the fabric to a fixed point from the requirements
    function automatic void model(output logic [N-1:0] y, output logic [N-1:0] cf);
        logic [N-1:0] cur, nxt;
        logic [3:0] slot, taken, m;
        int offs [4];
        int nb, s;
        offs[0] = -2; offs[1] = -1; offs[2] = 1; offs[3] = 2;
        cur = '0; nxt = '0; cf = '0;
        for (int it = 0; it < N; it++) begin
            for (int c = 0; c < N; c++) begin
                slot = '0; taken = '0; cf[c] = 1'b0;
                for (int k = 0; k < 4; k++) begin
                    if (b_nen[c][k]) begin
                        nb = wrap(c + offs[k]);
                        s  = (c < N/2) ? k : 3 - k;
                        slot[s]  = cur[nb];
                        taken[s] = 1'b1;
                    end
                end
                for (int t = 0; t < 4; t++) begin
                    if (b_gen[c][t]) begin
                        if (taken[t]) cf[c] = 1'b1;
                        else if (b_idx[c][t] < Q) slot[t] = b_pins[t*Q + int'(b_idx[c][t])];
                    end
                end
                for (int k = 0; k < 4; k++) m[k] = slot[b_xs[c][k]];
                case (b_sel[c])
                    2'b00: nxt[c] = m[0];
                    2'b01: nxt[c] = m[1];
                    2'b11: nxt[c] = m[2];
                    default: nxt[c] = m[3];
                endcase
            end
            cur = nxt;
        end
        y = cur;
    endfunction

    initial begin
        logic [N-1:0] ey, ecf;
        int rank [N];
        int offs [4];
        int nbc [4];
        offs[0] = -2; offs[1] = -1; offs[2] = 1; offs[3] = 2;
        void'($urandom(32'd20240611));
        clear_cfg();
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10: all-zero inputs give all-zero outputs
        chk("R10 zero mux", 128'(mux_o), '0);
        chk("R10 zero conflict", 128'(conflict_o), '0);

        // R1: group C pin 3 reaches cell 5 through slot 2
        @(posedge clk);
        b_gen[5][2] = 1; b_idx[5][2] = 3; b_xs[5][0] = 2'd2; b_pins[2*Q+3] = 1'b1;
        @(negedge clk); chk("R1 group pin high", 128'(mux_o[5]), 128'(1));
        @(posedge clk); b_pins = ~b_pins;
        @(negedge clk); chk("R1 group pin low", 128'(mux_o[5]), 128'(0));
        // R1: index beyond the group reads 0
        @(posedge clk); b_pins = '1; b_idx[5][2] = Q;
        @(negedge clk); chk("R1 index out of range", 128'(mux_o[5]), 128'(0));
        // R2: unused slot reads 0
        @(posedge clk); b_idx[5][2] = 3; b_xs[5][0] = 2'd1;
        @(negedge clk); chk("R2 empty slot", 128'(mux_o[5]), 128'(0));

        // R7: select encoding, one-hot pin per slot
        @(posedge clk); clear_cfg();
        for (int s = 0; s < 4; s++) begin
            b_gen[7][s] = 1; b_idx[7][s] = s; b_xs[7][s] = 2'(s);
        end
        for (int t = 0; t < 4; t++) begin
            for (int m = 0; m < 4; m++) begin
                @(posedge clk);
                b_pins = '0; b_pins[t*Q + t] = 1'b1; b_sel[7] = code_of(m);
                @(negedge clk);
                chk("R7 select encoding", 128'(mux_o[7]), 128'(t == m));
            end
        end
        // R6: crossbar fan-out of one slot to all inputs
        for (int k = 0; k < 4; k++) b_xs[7][k] = 2'd2;
        for (int m = 0; m < 4; m++) begin
            @(posedge clk); b_pins = '0; b_pins[2*Q+2] = 1'b1; b_sel[7] = code_of(m);
            @(negedge clk); chk("R6 crossbar fan-out", 128'(mux_o[7]), 128'(1));
        end

        // R8: one pin feeds every cell
        @(posedge clk); clear_cfg();
        for (int c = 0; c < N; c++) begin b_gen[c][0] = 1; b_idx[c][0] = 4; end
        b_pins[4] = 1'b1;
        @(negedge clk); chk("R8 fan-out high", 128'(mux_o), 128'({N{1'b1}}));
        @(posedge clk); b_pins = ~b_pins;
        @(negedge clk); chk("R8 fan-out low", 128'(mux_o), 128'(0));

        // R3: normal cell 13, offset -2 lands in slot 0
        @(posedge clk); clear_cfg();
        b_gen[11][0] = 1; b_nen[13][0] = 1; b_pins[0] = 1'b1;
        @(negedge clk); chk("R3 normal slot", 128'(mux_o[13]), 128'(1));
        @(posedge clk); b_xs[13][0] = 2'd1;
        @(negedge clk); chk("R3 normal other slot empty", 128'(mux_o[13]), 128'(0));
        // R3: reflected cell 50, offset +2 lands in slot 0
        @(posedge clk); clear_cfg();
        b_gen[52][0] = 1; b_nen[50][3] = 1; b_pins[0] = 1'b1;
        @(negedge clk); chk("R3 reflected slot", 128'(mux_o[50]), 128'(1));
        @(posedge clk); b_pins[0] = 1'b0;
        @(negedge clk); chk("R3 reflected follows pin", 128'(mux_o[50]), 128'(0));

        // R4: wrap at both ends
        @(posedge clk); clear_cfg();
        b_gen[N-2][1] = 1; b_idx[N-2][1] = 7; b_xs[N-2][0] = 2'd1;
        b_nen[0][0] = 1; b_pins[Q+7] = 1'b1;
        @(negedge clk); chk("R4 wrap low end", 128'(mux_o[0]), 128'(1));
        @(posedge clk); clear_cfg();
        b_gen[0][3] = 1; b_idx[0][3] = 9; b_xs[0][0] = 2'd3;
        b_nen[N-1][2] = 1; b_xs[N-1][0] = 2'd1; b_pins[3*Q+9] = 1'b1;
        @(negedge clk); chk("R4 wrap high end", 128'(mux_o[N-1]), 128'(1));

        // R5: neighbour beats group in the same slot
        @(posedge clk); clear_cfg();
        b_gen[12][2] = 1; b_xs[12][0] = 2'd2;
        b_nen[13][1] = 1; b_gen[13][1] = 1; b_xs[13][0] = 2'd1;
        b_pins[Q] = 1'b1;
        @(negedge clk);
        chk("R5 neighbour priority", 128'(mux_o[13]), 128'(0));
        chk("R5 conflict flag", 128'(conflict_o), 128'(1) << 13);
        @(posedge clk); b_pins = '0; b_pins[2*Q] = 1'b1;
        @(negedge clk); chk("R5 neighbour value", 128'(mux_o[13]), 128'(1));

        // R9: 16:1 through four neighbours of cell 30
        @(posedge clk); clear_cfg();
        nbc[0] = 28; nbc[1] = 29; nbc[2] = 31; nbc[3] = 32;
        for (int k = 0; k < 4; k++) begin
            b_nen[30][k] = 1; b_xs[30][k] = 2'(k);
            for (int s = 0; s < 4; s++) begin
                b_gen[nbc[k]][s] = 1; b_idx[nbc[k]][s] = k*4 + s; b_xs[nbc[k]][s] = 2'(s);
            end
        end
        for (int o = 0; o < 4; o++) begin
            for (int i = 0; i < 4; i++) begin
                @(posedge clk);
                b_sel[30] = code_of(o); b_sel[nbc[o]] = code_of(i);
                b_pins = '0; b_pins[i*Q + o*4 + i] = 1'b1;
                @(negedge clk); chk("R9 16:1 hit", 128'(mux_o[30]), 128'(1));
                @(posedge clk); b_pins = ~b_pins;
                @(negedge clk); chk("R9 16:1 miss", 128'(mux_o[30]), 128'(0));
            end
        end

        // Random acyclic configurations, chains up to LV-1 hops (R1-style mix)
        for (int it = 0; it < 200; it++) begin
            @(posedge clk);
            for (int c = 0; c < N; c++) rank[c] = $urandom % LV;
            for (int c = 0; c < N; c++) begin
                b_sel[c] = 2'($urandom);
                for (int k = 0; k < 4; k++) begin
                    b_idx[c][k] = $urandom % (Q + 4);
                    b_gen[c][k] = 1'($urandom);
                    b_xs[c][k]  = 2'($urandom);
                    b_nen[c][k] = (rank[wrap(c + offs[k])] < rank[c]) && ($urandom % 3 == 0);
                end
            end
            for (int p = 0; p < N; p++) b_pins[p] = 1'($urandom);
            model(ey, ecf);
            @(negedge clk);
            chk("R9 random mux", 128'(mux_o), 128'(ey));
            chk("R5 random conflict", 128'(conflict_o), 128'(ecf));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule